// File: doc/BRIEF.md
# Flash Common Memory Bridge

This block connects the common-memory side of a card-style host bus to a parallel flash device with a 16-bit data bus. The host presents an address, active-low chip enable, read and write strobes, write data, and a width request. The bridge turns these into the flash's active-low control lines, byte-mode select and address bus. It drives the flash data bus during writes and returns read data to the host on the correct lane.

In byte accesses, the lowest address bit picks which half of the flash word is used. An odd host byte address maps to the flash high byte and an even one to the low byte. In word accesses that bit is forced low, and address bit 1 is the lowest bit that matters. The flash reports busy on a level-mode, active-low status pin. The bridge passes it to the host ready/busy line through a short synchronizer. An active-low wait input is forwarded to the host wait line in the same way. A flash without a wait pin ties that input high.

The host bus is a strobe bus and has no valid/ready handshake. The host side has no way to be held off except the wait and ready/busy lines, and the bridge applies no back-pressure of its own. After reset the bridge holds the flash in reset for a fixed number of clocks. During that time it reports busy and blocks all flash strobes.

Top module: `flash_cm_bridge`

## Requirements
- R1: `mem_byte_n` equals `host_wide`. A value of 1 requests a 16-bit access and 0 requests an 8-bit access (byte select active low).
- R2: `mem_addr[10:1]` equals `host_addr[10:1]`. `mem_addr[0]` equals `host_addr[0]` in 8-bit mode and is 0 in 16-bit mode.
- R3: On a read in 16-bit mode, `host_rdata` equals the full flash word. In 8-bit mode, `host_rdata[7:0]` carries the byte the flash presents on `mem_dq[7:0]`, and `host_rdata[15:8]` is 0. Odd host addresses reach the flash high byte and even addresses the low byte.
- R4: Out of reset, `mem_ce_n` equals `host_ce_n`. `mem_we_n` is low exactly when both `host_ce_n` and `host_we_n` are low. `mem_oe_n` is low exactly when `host_ce_n` and `host_oe_n` are low and `host_we_n` is high, so a write blocks the read strobe.
- R5: `mem_dq` is driven only while `mem_we_n` is low, and is high impedance at all other times. The value driven is `host_wdata` in 16-bit mode and `{8'h00, host_wdata[7:0]}` in 8-bit mode.
- R6: `host_rdata_oe` is high exactly while `mem_oe_n` is low. When it is low, `host_rdata` is 0.
- R7: `host_rdy` (low means busy) takes the value `mem_sts_n` had two rising clock edges earlier. This applies once the flash reset has been released.
- R8: `host_wait_n` takes the value `mem_wait_n` had two rising edges earlier. If `mem_wait_n` is held high, `host_wait_n` stays high.
- R9: While `rst` is high and for the first RST_HOLD (default 4) rising edges after it falls, the following hold: `mem_rst_n` is low, `host_rdy` is low, and `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high. `mem_rst_n` rises on the RST_HOLD-th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 11 | Host byte address |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_oe_n | input | 1 | Host read strobe, active low |
| host_we_n | input | 1 | Host write strobe, active low |
| host_wide | input | 1 | Width request: 1 word, 0 byte |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data toward host |
| host_rdata_oe | output | 1 | Host data bus drive enable |
| host_rdy | output | 1 | Ready/busy, low when busy |
| host_wait_n | output | 1 | Wait toward host, active low |
| mem_sts_n | input | 1 | Flash status, low when busy |
| mem_wait_n | input | 1 | Flash wait, active low |
| mem_ce_n | output | 1 | Flash chip enable, active low |
| mem_oe_n | output | 1 | Flash output enable, active low |
| mem_we_n | output | 1 | Flash write enable, active low |
| mem_rst_n | output | 1 | Flash reset, active low |
| mem_byte_n | output | 1 | Flash byte mode, low selects 8-bit |
| mem_addr | output | 11 | Flash address bus |
| mem_dq | inout | 16 | Flash data bus |

## Verification
The assertions take two things for granted. First, the flash never drives `mem_dq` while the bridge is writing. Second, the status and wait inputs hold steady across a sampling edge, so the two-edge delay can be compared exactly. The bench's flash model drives the data bus only while `mem_oe_n` is low, and that line cannot be low while `mem_we_n` is. Status and wait are changed only on falling edges, so every change is settled before the next rising edge.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic {
    LANE_BYTE = 1'b0,
    LANE_WORD = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/fb_addr_map.sv
module fb_addr_map
  import fb_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] host_addr,
  input  lane_mode_e        mode,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_byte_n
);
  // upper bits go straight through; bit 0 only selects a byte in 8-bit mode
  always_comb begin
    mem_addr[ADDR_W-1:1] = host_addr[ADDR_W-1:1];
    mem_addr[0]          = (mode == LANE_BYTE) ? host_addr[0] : 1'b0;
    mem_byte_n           = (mode == LANE_WORD);
  end
endmodule

// File: rtl/fb_data_lane.sv
module fb_data_lane
  import fb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  lane_mode_e        mode,
  input  logic              wr_act,
  input  logic              rd_act,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdata_oe
);
  localparam int LANE_W = DATA_W / 2;

  always_comb begin
    dq_oe = wr_act;
    if (mode == LANE_WORD) dq_out = host_wdata;
    else                   dq_out = {{LANE_W{1'b0}}, host_wdata[LANE_W-1:0]};
  end

  // in byte mode the flash returns the chosen byte on its low lane
  always_comb begin
    host_rdata_oe = rd_act;
    host_rdata    = '0;
    if (rd_act) begin
      if (mode == LANE_WORD) host_rdata = dq_in;
      else                   host_rdata = {{LANE_W{1'b0}}, dq_in[LANE_W-1:0]};
    end
  end
endmodule

// File: rtl/fb_sync.sv
module fb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RST_VAL;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fb_reset_seq.sv
module fb_reset_seq #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  output logic released
);
  localparam int CNT_W = $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(HOLD);

  logic [CNT_W-1:0] cnt;
  logic             rel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      rel_q <= 1'b0;
    end else begin
      if (cnt != TOP) cnt <= cnt + 1'b1;
      if (cnt == LAST) rel_q <= 1'b1;
    end
  end

  assign released = rel_q;
endmodule

// File: rtl/flash_cm_bridge.sv
module flash_cm_bridge
  import fb_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 16,
  parameter int SYNC_DEPTH = 2,
  parameter int RST_HOLD  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_ce_n,
  input  logic              host_oe_n,
  input  logic              host_we_n,
  input  logic              host_wide,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdata_oe,
  output logic              host_rdy,
  output logic              host_wait_n,
  input  logic              mem_sts_n,
  input  logic              mem_wait_n,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_rst_n,
  output logic              mem_byte_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq
);
  lane_mode_e        mode;
  logic              live;
  logic              ce_act, wr_act, rd_act;
  logic              sts_q, wait_q;
  logic [DATA_W-1:0] dq_out;
  logic              dq_oe;

  assign mode = host_wide ? LANE_WORD : LANE_BYTE;

  fb_reset_seq #(.HOLD(RST_HOLD)) u_rseq (
    .clk(clk), .rst(rst), .released(live)
  );

  // strobes are qualified by the released flash reset; write beats read
  always_comb begin
    ce_act   = ~host_ce_n & live;
    wr_act   = ce_act & ~host_we_n;
    rd_act   = ce_act & ~host_oe_n & host_we_n;
    mem_ce_n = ~ce_act;
    mem_we_n = ~wr_act;
    mem_oe_n = ~rd_act;
  end

  fb_addr_map #(.ADDR_W(ADDR_W)) u_amap (
    .host_addr(host_addr), .mode(mode),
    .mem_addr(mem_addr), .mem_byte_n(mem_byte_n)
  );

  fb_data_lane #(.DATA_W(DATA_W)) u_lane (
    .mode(mode), .wr_act(wr_act), .rd_act(rd_act),
    .host_wdata(host_wdata), .dq_in(mem_dq),
    .dq_out(dq_out), .dq_oe(dq_oe),
    .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe)
  );

  assign mem_dq = dq_oe ? dq_out : {DATA_W{1'bz}};

  fb_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_sts (
    .clk(clk), .rst(rst), .d(mem_sts_n), .q(sts_q)
  );

  fb_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_wait (
    .clk(clk), .rst(rst), .d(mem_wait_n), .q(wait_q)
  );

  assign host_rdy    = live & sts_q;
  assign host_wait_n = wait_q;
  assign mem_rst_n   = live;
endmodule

// File: rtl/flash_cm_bridge_chk.sv
module flash_cm_bridge_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_ce_n,
  input logic              host_we_n,
  input logic              host_wide,
  input logic              host_rdata_oe,
  input logic              host_rdy,
  input logic              host_wait_n,
  input logic              mem_sts_n,
  input logic              mem_wait_n,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_rst_n,
  input logic              mem_byte_n,
  input logic [ADDR_W-1:0] mem_addr
);
  AST_WIDTH_SELECT: assert property (@(posedge clk) disable iff (rst)
    mem_byte_n == host_wide); // R1
  AST_WORD_A0_LOW: assert property (@(posedge clk) disable iff (rst)
    host_wide |-> (mem_addr[0] == 1'b0 && mem_addr[ADDR_W-1:1] == host_addr[ADDR_W-1:1])); // R2
  AST_NO_RD_DURING_WR: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n); // R4
  AST_CE_FOLLOWS_HOST: assert property (@(posedge clk) disable iff (rst)
    mem_rst_n |-> (mem_ce_n == host_ce_n)); // R4
  AST_RDATA_OE_MATCH: assert property (@(posedge clk) disable iff (rst)
    host_rdata_oe == !mem_oe_n); // R6
  AST_READY_DELAY: assert property (@(posedge clk) disable iff (rst)
    (mem_rst_n && $past(mem_rst_n, 2)) |-> (host_rdy == $past(mem_sts_n, 2))); // R7
  AST_WAIT_DELAY: assert property (@(posedge clk) disable iff (rst)
    (mem_rst_n && $past(mem_rst_n, 2)) |-> (host_wait_n == $past(mem_wait_n, 2))); // R8
  AST_BUSY_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mem_rst_n |-> (!host_rdy && mem_ce_n && mem_oe_n && mem_we_n)); // R9
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    host_ce_n |-> (mem_we_n && mem_oe_n)); // R4
endmodule

bind flash_cm_bridge flash_cm_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_ce_n(host_ce_n),
  .host_we_n(host_we_n), .host_wide(host_wide), .host_rdata_oe(host_rdata_oe),
  .host_rdy(host_rdy), .host_wait_n(host_wait_n), .mem_sts_n(mem_sts_n),
  .mem_wait_n(mem_wait_n), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_rst_n(mem_rst_n), .mem_byte_n(mem_byte_n),
  .mem_addr(mem_addr)
);

// File: tb/sim_flash_cm_bridge.sv
module sim_flash_cm_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] host_addr = '0;
  logic        host_ce_n = 1'b1, host_oe_n = 1'b1, host_we_n = 1'b1;
  logic        host_wide = 1'b1;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_rdata_oe, host_rdy, host_wait_n;
  logic        mem_sts_n = 1'b1, mem_wait_n = 1'b1;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_rst_n, mem_byte_n;
  logic [10:0] mem_addr;
  wire  [15:0] mem_dq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // flash model: word content derived from the word address
  function automatic logic [15:0] flash_word(input logic [10:0] a);
    return {a[10:1], 6'h2B} ^ 16'h9C00;
  endfunction

  logic [15:0] model_q;
  always_comb begin
    if (mem_byte_n) model_q = flash_word(mem_addr);
    else model_q = {8'h00, mem_addr[0] ? flash_word(mem_addr)[15:8] : flash_word(mem_addr)[7:0]};
  end
  assign mem_dq = !mem_oe_n ? model_q : 16'hzzzz;

  flash_cm_bridge u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_ce_n(host_ce_n),
    .host_oe_n(host_oe_n), .host_we_n(host_we_n), .host_wide(host_wide),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
    .host_rdy(host_rdy), .host_wait_n(host_wait_n), .mem_sts_n(mem_sts_n),
    .mem_wait_n(mem_wait_n), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_rst_n(mem_rst_n), .mem_byte_n(mem_byte_n),
    .mem_addr(mem_addr), .mem_dq(mem_dq)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    host_ce_n = 1'b1; host_oe_n = 1'b1; host_we_n = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R9", "rst_n in reset", {31'd0, mem_rst_n}, 32'd0);
    check("R9", "rdy in reset", {31'd0, host_rdy}, 32'd0);
    check("R9", "wait in reset", {31'd0, host_wait_n}, 32'd1);
    host_ce_n = 1'b0; host_oe_n = 1'b0; #1;
    check("R9", "oe blocked in reset", {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'd7);
    idle();
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R9", "rst_n before hold end", {31'd0, mem_rst_n}, 32'd0);
    check("R9", "rdy busy in hold", {31'd0, host_rdy}, 32'd0);
    @(negedge clk); #1;
    check("R9", "rst_n at hold end", {31'd0, mem_rst_n}, 32'd1);
    check("R7", "rdy after release", {31'd0, host_rdy}, 32'd1);
  endtask

  task automatic t_word_read(input logic [10:0] a);
    @(negedge clk);
    host_wide = 1'b1; host_addr = a; host_ce_n = 1'b0; host_oe_n = 1'b0; #1;
    check("R1", "byte_n word", {31'd0, mem_byte_n}, 32'd1);
    check("R2", "word addr", {21'd0, mem_addr}, {21'd0, a[10:1], 1'b0});
    check("R3", "word data", {16'd0, host_rdata}, {16'd0, flash_word(a)});
    check("R6", "rdata_oe on read", {31'd0, host_rdata_oe}, 32'd1);
    check("R4", "strobes read", {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'd1);
    idle(); #1;
    check("R6", "rdata idle zero", {15'd0, host_rdata_oe, host_rdata}, 32'd0);
  endtask

  task automatic t_byte_read(input logic [10:0] a);
    logic [15:0] w;
    w = flash_word({a[10:1], 1'b0});
    @(negedge clk);
    host_wide = 1'b0; host_addr = a; host_ce_n = 1'b0; host_oe_n = 1'b0; #1;
    check("R1", "byte_n byte", {31'd0, mem_byte_n}, 32'd0);
    check("R2", "byte addr", {21'd0, mem_addr}, {21'd0, a});
    check("R3", a[0] ? "odd byte high lane" : "even byte low lane",
          {16'd0, host_rdata}, {24'd0, a[0] ? w[15:8] : w[7:0]});
    idle();
  endtask

  task automatic t_write(input logic wide, input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wide = wide; host_addr = a; host_wdata = d; #1;
    check("R5", "dq released idle", {16'd0, mem_dq}, {16'd0, 16'hzzzz});
    host_ce_n = 1'b0; host_we_n = 1'b0; #1;
    check("R4", "strobes write", {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'd2);
    check("R5", "dq write value", {16'd0, mem_dq}, {16'd0, wide ? d : {8'h00, d[7:0]}});
    host_oe_n = 1'b0; #1;
    check("R4", "write blocks read", {30'd0, mem_oe_n, host_rdata_oe}, 32'd2);
    idle(); #1;
    check("R5", "dq released after", {16'd0, mem_dq}, {16'd0, 16'hzzzz});
  endtask

  task automatic t_status();
    @(negedge clk); mem_sts_n = 1'b0;
    @(negedge clk); #1;
    check("R7", "rdy one edge", {31'd0, host_rdy}, 32'd1);
    @(negedge clk); #1;
    check("R7", "rdy busy two edges", {31'd0, host_rdy}, 32'd0);
    mem_sts_n = 1'b1;
    @(negedge clk); #1;
    check("R7", "rdy still busy", {31'd0, host_rdy}, 32'd0);
    @(negedge clk); #1;
    check("R7", "rdy ready again", {31'd0, host_rdy}, 32'd1);
  endtask

  task automatic t_wait();
    repeat (5) @(negedge clk);
    #1;
    check("R8", "wait idle high", {31'd0, host_wait_n}, 32'd1);
    mem_wait_n = 1'b0;
    @(negedge clk); #1;
    check("R8", "wait one edge", {31'd0, host_wait_n}, 32'd1);
    @(negedge clk); #1;
    check("R8", "wait asserted", {31'd0, host_wait_n}, 32'd0);
    mem_wait_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R8", "wait released", {31'd0, host_wait_n}, 32'd1);
  endtask

  task automatic t_no_ce();
    @(negedge clk);
    host_ce_n = 1'b1; host_oe_n = 1'b0; host_we_n = 1'b0; #1;
    check("R4", "no strobe without ce", {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'd7);
    check("R5", "dq z without ce", {16'd0, mem_dq}, {16'd0, 16'hzzzz});
    idle();
  endtask

  initial begin
    t_reset();
    t_word_read(11'h2A6);
    t_word_read(11'h5D9);
    t_byte_read(11'h2A6);
    t_byte_read(11'h2A7);
    t_byte_read(11'h7FF);
    t_write(1'b1, 11'h155, 16'hBEEF);
    t_write(1'b0, 11'h0C3, 16'h5A3C);
    t_no_ce();
    t_status();
    t_wait();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule